// File: doc/BRIEF.md
# Video coprocessor register interface

This block is the processor-facing register front end of a tile-based video coprocessor. The host processor reaches it through an eight-entry register window. An outside decoder asserts `cpu_sel` anywhere in a larger repeating range and passes only the three low address bits. Behind the window sit a control byte, a mask byte, a status byte with read side effects, an index and data pair for the 256-byte sprite attribute RAM, a two-write scroll port, and a two-write video-memory address port with its data port. Writes through the scroll and address ports share one toggle, and the ports build the 15-bit temporary and current video addresses that the renderer uses.

The renderer drives single-cycle strobes for vertical blank start and end, sprite-zero hit and sprite overflow. The block keeps the status flags and raises a level interrupt request while vertical blank is set and interrupts are enabled. A separate trigger input starts a page copy. The block reads 256 bytes of host memory, one every two cycles, and writes them into the sprite RAM through the sprite-data path.

A controller FSM orders the work. `ST_IDLE` takes host accesses and the copy trigger. `ST_VRD` is the single wait cycle of a video-data read. `ST_DMA_FETCH` and `ST_DMA_STORE` alternate through the page copy. The transitions are:
- IDLE to VRD on a data-port read.
- IDLE to DMA_FETCH on a trigger.
- VRD to IDLE.
- DMA_FETCH to DMA_STORE.
- DMA_STORE to DMA_FETCH until the 256th byte, then to IDLE.

Top module: `vpu_regif`

## Requirements
- R1: After reset the control, mask, current address and temporary address outputs are zero, and both `nmi` and `cpu_rvalid` are low.
- R2: A read of register 2 returns {vblank, sprite-zero hit, overflow, bus_latch[4:0]} in bits 7..5 and 4..0. For any register other than 7, `cpu_rvalid` is high for one cycle, one cycle after the read strobe.
- R3: A status read clears vblank and resets the shared write toggle, so that the next scroll or address write counts as a first write. When a vblank-start strobe arrives in the same cycle as the read, the read returns the old flags and vblank ends up set.
- R4: The hit and overflow strobes set their flags. A status read leaves those two flags set. A vblank-end strobe clears vblank, hit and overflow.
- R5: `nmi` is high exactly while vblank is set and control bit 7 is one.
- R6: A control write copies data[1:0] into temporary[11:10]. The first scroll write loads temporary[4:0] from data[7:3] and fine X from data[2:0]. The second scroll write loads temporary[9:5] from data[7:3] and temporary[14:12] from data[2:0].
- R7: The first address write loads temporary[13:8] from data[5:0] and clears temporary[14]. The second address write loads temporary[7:0] and copies the whole temporary address into the current address.
- R8: A write to register 7 drives `vm_we` with the current address's low 14 bits and the data byte. The current address then advances by 32 when control bit 2 is one and by 1 otherwise, modulo 2^15. Reads of register 7 advance it by the same amount.
- R9: A register 7 read outside the palette range returns the read buffer's previous content, with `cpu_rvalid` two cycles after the strobe. The byte fetched from video memory then replaces the buffer.
- R10: A register 7 read whose address has bits 13..8 equal to 0x3F returns the fetched byte itself, and the buffer is loaded with that same byte.
- R11: A write to register 4 stores the byte into sprite RAM at the sprite index, which register 3 sets. The index then increments modulo 256.
- R12: A trigger with page P on `cpu_wdata` copies host bytes {P, i} for i = 0..255 into sprite RAM at successive indices, starting from the current index. `dma_busy` stays high for 512 cycles, and host register accesses during the copy have no effect.
- R13: Reads of registers 0, 1, 3, 4, 5 and 6 return the bus latch. The bus latch holds the last byte written to, or returned from, the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register window selected |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | 3 | Register index |
| cpu_wdata | input | 8 | Write data, also the page number on a trigger |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid pulse |
| dma_trig | input | 1 | Page-copy trigger |
| dma_busy | output | 1 | Page copy in progress |
| dma_rd | output | 1 | Host memory read request |
| dma_addr | output | 16 | Host memory byte address |
| dma_rdata | input | 8 | Host memory data, one cycle after dma_rd |
| vm_addr | output | 14 | Video memory address |
| vm_wdata | output | 8 | Video memory write data |
| vm_we | output | 1 | Video memory write |
| vm_re | output | 1 | Video memory read, data one cycle later |
| vm_rdata | input | 8 | Video memory read data |
| spr_addr | output | 8 | Sprite RAM address |
| spr_wdata | output | 8 | Sprite RAM write data |
| spr_we | output | 1 | Sprite RAM write |
| vbl_start | input | 1 | Vertical blank start strobe |
| vbl_end | input | 1 | Vertical blank end strobe |
| spr0_hit | input | 1 | Sprite-zero hit strobe |
| spr_ovf | input | 1 | Sprite overflow strobe |
| nmi | output | 1 | Interrupt request level |
| ctrl_out | output | 8 | Control byte |
| mask_out | output | 8 | Mask byte |
| scroll_fine_x | output | 3 | Fine horizontal scroll |
| cur_addr | output | 15 | Current video address |
| tmp_addr | output | 15 | Temporary video address |

## Verification
A stuck or wrongly reset write toggle shows up within one write as a field landing in the wrong half of `tmp_addr`, or as `cur_addr` being loaded too early. A read-buffer or palette-detect fault shifts every data-port read result by one position in the read sequence, so the scoreboard catches it at the first read that follows. A flag-priority fault is visible on `nmi` in the cycle after the strobe. An index or count fault in the page copy leaves sprite RAM misaligned, and a sweep over all 256 entries after the copy ends reveals it.

// File: rtl/vpu_regif_pkg.sv
package vpu_regif_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VRD,
        ST_DMA_FETCH,
        ST_DMA_STORE
    } vpu_state_e;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_MASK   = 3'd1;
    localparam logic [2:0] REG_STAT   = 3'd2;
    localparam logic [2:0] REG_OADDR  = 3'd3;
    localparam logic [2:0] REG_ODATA  = 3'd4;
    localparam logic [2:0] REG_SCROLL = 3'd5;
    localparam logic [2:0] REG_VADDR  = 3'd6;
    localparam logic [2:0] REG_VDATA  = 3'd7;

    localparam int CTRL_INC_BIT = 2;
    localparam int CTRL_NMI_BIT = 7;
    localparam int VADDR_W      = 15;
endpackage

// File: rtl/vpu_status.sv
module vpu_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbl_start,
    input  logic       vbl_end,
    input  logic       spr0_hit,
    input  logic       spr_ovf,
    input  logic       stat_rd,
    input  logic       nmi_en,
    output logic [2:0] flags_o,
    output logic       nmi_o
);
    logic vbl_q, hit_q, ovf_q;

    // vblank: a start strobe wins over a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbl_q <= 1'b0;
            hit_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (vbl_start)
                vbl_q <= 1'b1;
            else if (vbl_end || stat_rd)
                vbl_q <= 1'b0;

            if (vbl_end)
                hit_q <= 1'b0;
            else if (spr0_hit)
                hit_q <= 1'b1;

            if (vbl_end)
                ovf_q <= 1'b0;
            else if (spr_ovf)
                ovf_q <= 1'b1;
        end
    end

    assign flags_o = {vbl_q, hit_q, ovf_q};
    assign nmi_o   = vbl_q & nmi_en;
endmodule

// File: rtl/vpu_addr_regs.sv
module vpu_addr_regs
    import vpu_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic               wr_scroll,
    input  logic               wr_vaddr,
    input  logic               stat_rd,
    input  logic               step,
    input  logic               inc32,
    input  logic [7:0]         wdata,
    output logic [VADDR_W-1:0] v_o,
    output logic [VADDR_W-1:0] t_o,
    output logic [2:0]         fine_x_o,
    output logic               toggle_o
);
    localparam logic [VADDR_W-1:0] STEP_ONE = VADDR_W'(1);
    localparam logic [VADDR_W-1:0] STEP_ROW = VADDR_W'(32);

    logic [VADDR_W-1:0] v_q, t_q;
    logic [2:0]         fx_q;
    logic               tg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= '0;
            t_q  <= '0;
            fx_q <= '0;
            tg_q <= 1'b0;
        end else begin
            if (stat_rd)
                tg_q <= 1'b0;

            if (wr_ctrl)
                t_q[11:10] <= wdata[1:0];

            if (wr_scroll) begin
                if (tg_q) begin
                    t_q[9:5]   <= wdata[7:3];
                    t_q[14:12] <= wdata[2:0];
                end else begin
                    t_q[4:0] <= wdata[7:3];
                    fx_q     <= wdata[2:0];
                end
                tg_q <= ~tg_q;
            end

            if (wr_vaddr) begin
                if (tg_q) begin
                    t_q[7:0] <= wdata;
                    v_q      <= {t_q[14:8], wdata};
                end else begin
                    t_q[14]   <= 1'b0;
                    t_q[13:8] <= wdata[5:0];
                end
                tg_q <= ~tg_q;
            end

            if (step)
                v_q <= v_q + (inc32 ? STEP_ROW : STEP_ONE);
        end
    end

    assign v_o      = v_q;
    assign t_o      = t_q;
    assign fine_x_o = fx_q;
    assign toggle_o = tg_q;
endmodule

// File: rtl/vpu_regif.sv
module vpu_regif
    import vpu_regif_pkg::*;
#(
    parameter int OAM_AW  = 8,
    parameter int VMEM_AW = 14,
    parameter int PAGE_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_sel,
    input  logic                     cpu_wr,
    input  logic                     cpu_rd,
    input  logic [2:0]               cpu_addr,
    input  logic [7:0]               cpu_wdata,
    output logic [7:0]               cpu_rdata,
    output logic                     cpu_rvalid,
    input  logic                     dma_trig,
    output logic                     dma_busy,
    output logic                     dma_rd,
    output logic [PAGE_W+OAM_AW-1:0] dma_addr,
    input  logic [7:0]               dma_rdata,
    output logic [VMEM_AW-1:0]       vm_addr,
    output logic [7:0]               vm_wdata,
    output logic                     vm_we,
    output logic                     vm_re,
    input  logic [7:0]               vm_rdata,
    output logic [OAM_AW-1:0]        spr_addr,
    output logic [7:0]               spr_wdata,
    output logic                     spr_we,
    input  logic                     vbl_start,
    input  logic                     vbl_end,
    input  logic                     spr0_hit,
    input  logic                     spr_ovf,
    output logic                     nmi,
    output logic [7:0]               ctrl_out,
    output logic [7:0]               mask_out,
    output logic [2:0]               scroll_fine_x,
    output logic [VADDR_W-1:0]       cur_addr,
    output logic [VADDR_W-1:0]       tmp_addr
);
    localparam logic [OAM_AW-1:0] OAM_ONE  = OAM_AW'(1);
    localparam logic [5:0]        PAL_PAGE = 6'h3F;

    vpu_state_e state_q, state_d;

    logic               wr_hit, rd_hit, dma_go;
    logic               step, oam_inc, stat_rd;
    logic               wr_ctrl, wr_scroll, wr_vaddr;
    logic [7:0]         ctrl_q, mask_q, latch_q, rbuf_q, rdata_q;
    logic               rvalid_q, pal_q;
    logic [OAM_AW-1:0]  oam_q, dma_cnt_q;
    logic [PAGE_W-1:0]  page_q;
    logic [2:0]         stat_flags;
    logic               wr_toggle;
    logic [VADDR_W-1:0] v_q, t_q;
    logic [2:0]         fx;
    logic [7:0]         reg_rd_val, vrd_val;

    // host accesses are only taken while the controller is idle
    assign wr_hit = cpu_sel & cpu_wr & (state_q == ST_IDLE);
    assign rd_hit = cpu_sel & cpu_rd & ~cpu_wr & (state_q == ST_IDLE);
    assign dma_go = dma_trig & (state_q == ST_IDLE) & ~(cpu_sel & (cpu_wr | cpu_rd));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dma_go)
                    state_d = ST_DMA_FETCH;
                else if (rd_hit && cpu_addr == REG_VDATA)
                    state_d = ST_VRD;
            end
            ST_VRD:       state_d = ST_IDLE;
            ST_DMA_FETCH: state_d = ST_DMA_STORE;
            ST_DMA_STORE: state_d = (dma_cnt_q == '1) ? ST_IDLE : ST_DMA_FETCH;
        endcase
    end

    // ---------------- per-state strobes ----------------
    always_comb begin
        vm_we     = 1'b0;
        vm_re     = 1'b0;
        spr_we    = 1'b0;
        spr_wdata = cpu_wdata;
        dma_rd    = 1'b0;
        step      = 1'b0;
        oam_inc   = 1'b0;
        stat_rd   = 1'b0;
        wr_ctrl   = 1'b0;
        wr_scroll = 1'b0;
        wr_vaddr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_hit) begin
                    case (cpu_addr)
                        REG_CTRL:   wr_ctrl   = 1'b1;
                        REG_SCROLL: wr_scroll = 1'b1;
                        REG_VADDR:  wr_vaddr  = 1'b1;
                        REG_ODATA: begin
                            spr_we  = 1'b1;
                            oam_inc = 1'b1;
                        end
                        REG_VDATA: begin
                            vm_we = 1'b1;
                            step  = 1'b1;
                        end
                        default: ;
                    endcase
                end else if (rd_hit) begin
                    if (cpu_addr == REG_STAT)
                        stat_rd = 1'b1;
                    if (cpu_addr == REG_VDATA) begin
                        vm_re = 1'b1;
                        step  = 1'b1;
                    end
                end
            end
            ST_VRD: ;
            ST_DMA_FETCH: dma_rd = 1'b1;
            ST_DMA_STORE: begin
                spr_we    = 1'b1;
                spr_wdata = dma_rdata;
                oam_inc   = 1'b1;
            end
        endcase
    end

    assign reg_rd_val = (cpu_addr == REG_STAT) ? {stat_flags, latch_q[4:0]} : latch_q;
    assign vrd_val    = pal_q ? vm_rdata : rbuf_q;

    // ---------------- data registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            mask_q    <= '0;
            latch_q   <= '0;
            rbuf_q    <= '0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
            pal_q     <= 1'b0;
            oam_q     <= '0;
            dma_cnt_q <= '0;
            page_q    <= '0;
        end else begin
            rvalid_q <= 1'b0;
            if (wr_hit) begin
                latch_q <= cpu_wdata;
                case (cpu_addr)
                    REG_CTRL:  ctrl_q <= cpu_wdata;
                    REG_MASK:  mask_q <= cpu_wdata;
                    REG_OADDR: oam_q  <= cpu_wdata[OAM_AW-1:0];
                    default: ;
                endcase
            end
            if (rd_hit && cpu_addr != REG_VDATA) begin
                rdata_q  <= reg_rd_val;
                latch_q  <= reg_rd_val;
                rvalid_q <= 1'b1;
            end
            if (rd_hit && cpu_addr == REG_VDATA)
                pal_q <= (v_q[13:8] == PAL_PAGE);
            if (state_q == ST_VRD) begin
                rdata_q  <= vrd_val;
                latch_q  <= vrd_val;
                rbuf_q   <= vm_rdata;
                rvalid_q <= 1'b1;
            end
            if (oam_inc)
                oam_q <= oam_q + OAM_ONE;
            if (dma_go) begin
                page_q    <= cpu_wdata[PAGE_W-1:0];
                dma_cnt_q <= '0;
            end
            if (state_q == ST_DMA_STORE)
                dma_cnt_q <= dma_cnt_q + OAM_ONE;
        end
    end

    vpu_addr_regs u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_scroll(wr_scroll),
        .wr_vaddr (wr_vaddr),
        .stat_rd  (stat_rd),
        .step     (step),
        .inc32    (ctrl_q[CTRL_INC_BIT]),
        .wdata    (cpu_wdata),
        .v_o      (v_q),
        .t_o      (t_q),
        .fine_x_o (fx),
        .toggle_o (wr_toggle)
    );

    vpu_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .vbl_start(vbl_start),
        .vbl_end  (vbl_end),
        .spr0_hit (spr0_hit),
        .spr_ovf  (spr_ovf),
        .stat_rd  (stat_rd),
        .nmi_en   (ctrl_q[CTRL_NMI_BIT]),
        .flags_o  (stat_flags),
        .nmi_o    (nmi)
    );

    assign cpu_rdata     = rdata_q;
    assign cpu_rvalid    = rvalid_q;
    assign dma_busy      = (state_q == ST_DMA_FETCH) || (state_q == ST_DMA_STORE);
    assign dma_addr      = {page_q, dma_cnt_q};
    assign vm_addr       = v_q[VMEM_AW-1:0];
    assign vm_wdata      = cpu_wdata;
    assign spr_addr      = oam_q;
    assign ctrl_out      = ctrl_q;
    assign mask_out      = mask_q;
    assign scroll_fine_x = fx;
    assign cur_addr      = v_q;
    assign tmp_addr      = t_q;
endmodule

// File: rtl/vpu_regif_chk.sv
module vpu_regif_chk #(
    parameter int OAM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rvalid,
    input logic              vm_we,
    input logic              vm_re,
    input logic              spr_we,
    input logic [OAM_AW-1:0] spr_addr,
    input logic [OAM_AW-1:0] oam_q,
    input logic              dma_rd,
    input logic              dma_busy,
    input logic              nmi,
    input logic [7:0]        ctrl_out,
    input logic [14:0]       cur_addr,
    input logic              stat_rd,
    input logic              stat_vbl,
    input logic              wr_toggle,
    input logic              vbl_start
);
    localparam logic [OAM_AW-1:0] ONE = OAM_AW'(1);

    p_nmi_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> (ctrl_out[7] && stat_vbl));

    p_stat_clears_vbl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !vbl_start) |=> !stat_vbl);

    p_stat_clears_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !wr_toggle);

    p_vaddr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_we || vm_re) |=> (cur_addr == $past(cur_addr) + $past(ctrl_out[2] ? 15'd32 : 15'd1)));

    p_vdata_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vm_re |=> ##1 cpu_rvalid);

    p_oam_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spr_we |=> (oam_q == $past(spr_addr) + ONE));

    p_dma_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd |=> spr_we);

    p_dma_no_vmem_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> !(vm_we || vm_re));
endmodule

bind vpu_regif vpu_regif_chk #(.OAM_AW(OAM_AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rvalid(cpu_rvalid),
    .vm_we     (vm_we),
    .vm_re     (vm_re),
    .spr_we    (spr_we),
    .spr_addr  (spr_addr),
    .oam_q     (oam_q),
    .dma_rd    (dma_rd),
    .dma_busy  (dma_busy),
    .nmi       (nmi),
    .ctrl_out  (ctrl_out),
    .cur_addr  (cur_addr),
    .stat_rd   (stat_rd),
    .stat_vbl  (stat_flags[2]),
    .wr_toggle (wr_toggle),
    .vbl_start (vbl_start)
);

// File: tb/vpu_regif_tb_top.sv
module vpu_regif_tb_top;
    import vpu_regif_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic        dma_trig = 1'b0;
    logic        dma_busy, dma_rd;
    logic [15:0] dma_addr;
    logic [7:0]  dma_rdata = '0;
    logic [13:0] vm_addr;
    logic [7:0]  vm_wdata, vm_rdata = '0;
    logic        vm_we, vm_re;
    logic [7:0]  spr_addr, spr_wdata;
    logic        spr_we;
    logic        vbl_start = 1'b0, vbl_end = 1'b0, spr0_hit = 1'b0, spr_ovf = 1'b0;
    logic        nmi;
    logic [7:0]  ctrl_out, mask_out;
    logic [2:0]  scroll_fine_x;
    logic [14:0] cur_addr, tmp_addr;

    logic [7:0]  vmem [0:16383];
    logic [7:0]  smem [0:255];
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  bus_latch = '0;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpu_regif dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .dma_trig(dma_trig), .dma_busy(dma_busy), .dma_rd(dma_rd),
        .dma_addr(dma_addr), .dma_rdata(dma_rdata),
        .vm_addr(vm_addr), .vm_wdata(vm_wdata), .vm_we(vm_we), .vm_re(vm_re),
        .vm_rdata(vm_rdata),
        .spr_addr(spr_addr), .spr_wdata(spr_wdata), .spr_we(spr_we),
        .vbl_start(vbl_start), .vbl_end(vbl_end), .spr0_hit(spr0_hit), .spr_ovf(spr_ovf),
        .nmi(nmi), .ctrl_out(ctrl_out), .mask_out(mask_out),
        .scroll_fine_x(scroll_fine_x), .cur_addr(cur_addr), .tmp_addr(tmp_addr)
    );

    function automatic logic [7:0] host_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5C;
    endfunction

    // memory models behind the ports
    always @(posedge clk) begin
        if (vm_we) vmem[vm_addr] <= vm_wdata;
        if (vm_re) vm_rdata <= vmem[vm_addr];
        if (spr_we) smem[spr_addr] <= spr_wdata;
        if (dma_rd) dma_rdata <= host_byte(dma_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cpu_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected read data", cpu_rdata, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cpu_rdata === e, t, "read data", cpu_rdata, e);
            end
        end
    end

    task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
        bus_latch = d;
    endtask

    task automatic cpu_read(input logic [2:0] a, input logic [7:0] e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_rd = 1'b0;
        if (a != REG_VDATA)
            check(cpu_rvalid === 1'b1, req, "rvalid one cycle after read", cpu_rvalid, 1);
        else
            check(cpu_rvalid === 1'b0, "R9", "rvalid not yet after data read", cpu_rvalid, 0);
        @(negedge clk);
        if (a == REG_VDATA)
            check(cpu_rvalid === 1'b1, "R9", "rvalid two cycles after data read", cpu_rvalid, 1);
        bus_latch = e;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: vbl_start = 1'b1;
            1: vbl_end   = 1'b1;
            2: spr0_hit  = 1'b1;
            default: spr_ovf = 1'b1;
        endcase
        @(negedge clk);
        vbl_start = 1'b0; vbl_end = 1'b0; spr0_hit = 1'b0; spr_ovf = 1'b0;
    endtask

    task automatic set_vaddr(input logic [7:0] hi, input logic [7:0] lo);
        cpu_write(REG_VADDR, hi);
        cpu_write(REG_VADDR, lo);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int busy_cycles;
        int bad;
        for (int i = 0; i < 16384; i++) vmem[i] = 8'h00;
        for (int i = 0; i < 256; i++) smem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ctrl_out == 8'h00 && mask_out == 8'h00, "R1", "ctrl/mask reset", {ctrl_out, mask_out}, 0);
        check(cur_addr == 15'h0 && tmp_addr == 15'h0, "R1", "addresses reset", {cur_addr, tmp_addr}, 0);
        check(nmi == 1'b0 && cpu_rvalid == 1'b0, "R1", "nmi/rvalid reset", {nmi, cpu_rvalid}, 0);

        // R13 write-only readback gives bus latch
        cpu_write(REG_MASK, 8'h1E);
        check(mask_out == 8'h1E, "R13", "mask stored", mask_out, 8'h1E);
        cpu_read(REG_MASK, 8'h1E, "R13");

        // R2/R5/R3 vblank, interrupt and clearing read
        cpu_write(REG_CTRL, 8'h80);
        pulse(0);
        check(nmi == 1'b1, "R5", "nmi with vblank and enable", nmi, 1);
        cpu_read(REG_STAT, {3'b100, bus_latch[4:0]}, "R2");
        check(nmi == 1'b0, "R3", "nmi drops after status read", nmi, 0);
        cpu_read(REG_STAT, {3'b000, bus_latch[4:0]}, "R3");

        // R4 hit / overflow flags
        pulse(2);
        pulse(3);
        check(nmi == 1'b0, "R5", "no nmi without vblank", nmi, 0);
        cpu_read(REG_STAT, {3'b011, bus_latch[4:0]}, "R4");
        cpu_read(REG_STAT, {3'b011, bus_latch[4:0]}, "R4");
        pulse(1);
        cpu_read(REG_STAT, {3'b000, bus_latch[4:0]}, "R4");

        // R3 vblank start in the same cycle as a status read
        exp_q.push_back({3'b000, bus_latch[4:0]});
        tag_q.push_back("R3");
        @(negedge clk);
        cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_addr = REG_STAT; vbl_start = 1'b1;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_rd = 1'b0; vbl_start = 1'b0;
        bus_latch = {3'b000, bus_latch[4:0]};
        check(nmi == 1'b1, "R3", "vblank set wins over read", nmi, 1);
        cpu_read(REG_STAT, {3'b100, bus_latch[4:0]}, "R3");

        // R3 toggle reset, R6 scroll fields
        cpu_write(REG_SCROLL, 8'h7D);
        cpu_read(REG_STAT, {3'b000, bus_latch[4:0]}, "R3");
        cpu_write(REG_SCROLL, 8'h5E);
        check(tmp_addr[4:0] == 5'h0B && scroll_fine_x == 3'd6, "R3", "scroll after reset is first write",
              {tmp_addr[4:0], scroll_fine_x}, {5'h0B, 3'd6});
        cpu_write(REG_SCROLL, 8'hE3);
        check(tmp_addr == 15'h338B, "R6", "second scroll write", tmp_addr, 15'h338B);
        cpu_write(REG_CTRL, 8'h03);
        check(tmp_addr == 15'h3F8B && cur_addr == 15'h0, "R6", "ctrl nametable bits", tmp_addr, 15'h3F8B);

        // R7 address writes
        cpu_write(REG_VADDR, 8'h21);
        check(tmp_addr == 15'h218B && cur_addr == 15'h0, "R7", "first address write", tmp_addr, 15'h218B);
        cpu_write(REG_VADDR, 8'h08);
        check(tmp_addr == 15'h2108 && cur_addr == 15'h2108, "R7", "second address write", cur_addr, 15'h2108);

        // R8 data writes, step 1 then 32
        cpu_write(REG_VDATA, 8'h11);
        check(cur_addr == 15'h2109, "R8", "step by one", cur_addr, 15'h2109);
        cpu_write(REG_VDATA, 8'h22);
        cpu_write(REG_CTRL, 8'h07);
        cpu_write(REG_VDATA, 8'h33);
        check(cur_addr == 15'h212A, "R8", "step by 32", cur_addr, 15'h212A);
        check(vmem[14'h2108] == 8'h11 && vmem[14'h210A] == 8'h33, "R8", "memory writes",
              {vmem[14'h2108], vmem[14'h210A]}, 16'h1133);

        // R9 buffered reads
        set_vaddr(8'h21, 8'h08);
        cpu_read(REG_VDATA, 8'h00, "R9");
        check(cur_addr == 15'h2128, "R8", "read steps by 32", cur_addr, 15'h2128);
        cpu_write(REG_CTRL, 8'h03);
        set_vaddr(8'h21, 8'h09);
        cpu_read(REG_VDATA, 8'h11, "R9");
        cpu_read(REG_VDATA, 8'h22, "R9");

        // R10 palette reads
        set_vaddr(8'h3F, 8'h05);
        cpu_write(REG_VDATA, 8'h2A);
        set_vaddr(8'h3F, 8'h05);
        cpu_read(REG_VDATA, 8'h2A, "R10");
        set_vaddr(8'h21, 8'h08);
        cpu_read(REG_VDATA, 8'h2A, "R10");

        // R8 top of memory
        set_vaddr(8'h3F, 8'hFF);
        cpu_write(REG_VDATA, 8'h5A);
        check(cur_addr == 15'h4000, "R8", "carry past 14 bits", cur_addr, 15'h4000);
        cpu_write(REG_VDATA, 8'h6B);
        check(vmem[14'h0000] == 8'h6B && cur_addr == 15'h4001, "R8", "low 14 bits address memory",
              vmem[14'h0000], 8'h6B);

        // R11 sprite writes with index wrap
        cpu_write(REG_OADDR, 8'hFE);
        cpu_write(REG_ODATA, 8'h41);
        cpu_write(REG_ODATA, 8'h42);
        cpu_write(REG_ODATA, 8'h43);
        @(negedge clk);
        check(smem[8'hFE] == 8'h41 && smem[8'hFF] == 8'h42 && smem[8'h00] == 8'h43, "R11",
              "sprite index increments and wraps", {smem[8'hFE], smem[8'hFF], smem[8'h00]}, 24'h414243);
        cpu_read(REG_ODATA, bus_latch, "R13");

        // R12 page copy
        cpu_write(REG_OADDR, 8'h10);
        @(negedge clk);
        dma_trig = 1'b1; cpu_wdata = 8'h02;
        @(negedge clk);
        dma_trig = 1'b0;
        busy_cycles = 0;
        while (dma_busy && busy_cycles < 2000) begin
            busy_cycles++;
            if (busy_cycles == 10) begin
                cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = REG_MASK; cpu_wdata = 8'h99;
            end else begin
                cpu_sel = 1'b0; cpu_wr = 1'b0;
            end
            @(negedge clk);
        end
        cpu_sel = 1'b0; cpu_wr = 1'b0;
        check(busy_cycles == 512, "R12", "busy length", busy_cycles, 512);
        check(mask_out == 8'h1E, "R12", "write during copy ignored", mask_out, 8'h1E);
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] idx;
            idx = 8'(8'h10 + i);
            if (smem[idx] !== host_byte({8'h02, 8'(i)})) bad++;
        end
        check(bad == 0, "R12", "sprite RAM after copy (mismatches)", bad, 0);
        cpu_read(REG_MASK, bus_latch, "R12");
        cpu_write(REG_ODATA, 8'h77);
        @(negedge clk);
        check(smem[8'h10] == 8'h77, "R12", "index back at start after 256 bytes", smem[8'h10], 8'h77);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all reads answered", exp_q.size(), 0);
        finish_run();
    end
endmodule